// File: doc/BRIEF.md
# Fan PWM Controller with Interrupt Sequencing

This block drives a cooling fan through a single PWM pin. The period is a fixed build-time constant that software can read but never change. The high time comes from a width register that software writes. A temperature-threshold comparator can also supply a new width by itself. Software updates are deferred to the next period boundary, so the fan never sees a clipped or stretched pulse.

A four-source interrupt block reports the block's events. The sources are:

- a duty-cycle change;
- a tach fault strobe;
- a temperature-driven duty request;
- a new tach measurement strobe.

A temperature request first raises its own flag. The block then counts a settle interval before it announces that the PWM has changed, which gives the fan time to reach its new speed.

All registers sit behind a flat 32-bit register port. Writes are one cycle. Reads are combinational from the read address. A run bit keeps the datapath idle until software releases it.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset the following hold: `pwm_out` and `irq` are low, the run bit reads 0, the pending register reads 0, and the mask register (byte offset 0x40) reads 0xF.
- R2: The period register at offset 0xC0 always reads the `PERIOD` parameter, which is nonzero, and writes to it have no effect.
- R3: While bit 0 of the run register (offset 0x80) is 0:
  - `pwm_out` stays low;
  - the period counter is held at zero;
  - no event strobe, width write or settle expiry sets a pending bit.
- R4: With the run bit at 1, each period of `PERIOD` clocks drives `pwm_out` high for min(width, `PERIOD`) clocks. The high time starts at the first clock of the period. The width register sits at offset 0x84.
- R5: A new width value is applied only at a period boundary. The period during which it is written completes with the old width.
- R6: A software write to the width register sets pending bit 0 (PWM changed) in the cycle after the write.
- R7: A tach fault strobe sets pending bit 1. A new-measurement strobe sets pending bit 3.
- R8: A temperature request strobe does three things:
  - it sets pending bit 2 in the following cycle;
  - it loads its duty value into the width register;
  - it sets pending bit 0 exactly `SETTLE_CYCLES` clocks after the strobe edge.
- R9: The pending register at offset 0x44 is write-1-to-clear, and writing 0 to a bit leaves that bit unchanged. If an event and a clear hit the same bit in the same cycle, the event wins.
- R10: A mask bit of 1 disables its source. `irq` is high while any pending bit has a 0 mask bit. The source register at offset 0x48 reads pending AND NOT mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| tach_err | input | 1 | One-cycle tach fault strobe |
| tach_meas | input | 1 | One-cycle new-measurement strobe |
| temp_req | input | 1 | One-cycle temperature duty request |
| temp_duty | input | 16 | Width requested with `temp_req` |
| pwm_out | output | 1 | Fan PWM drive |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions assume three things about the inputs:
- the event strobes are synchronous to `clk`;
- `SETTLE_CYCLES` is at least 1;
- `PERIOD` fits in the width register.

The stimulus drives every input on the falling edge, so each strobe lasts exactly one rising edge. The bench uses a small configuration with a period of 8 and a settle interval of 20. Every width from 0 to one past the period is measured over a full period, after enough time for the boundary load to have occurred.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam logic [7:0] OFF_MASK   = 8'h40;
  localparam logic [7:0] OFF_PEND   = 8'h44;
  localparam logic [7:0] OFF_SRC    = 8'h48;
  localparam logic [7:0] OFF_RUN    = 8'h80;
  localparam logic [7:0] OFF_WIDTH  = 8'h84;
  localparam logic [7:0] OFF_PERIOD = 8'hC0;

  localparam int NSRC         = 4;
  localparam int EV_PWM_CHG   = 0;
  localparam int EV_TACH_ERR  = 1;
  localparam int EV_TEMP_REQ  = 2;
  localparam int EV_NEW_MEAS  = 3;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
  import fan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WID_W  = 16,
  parameter int PERIOD = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  input  logic              temp_load,
  input  logic [WID_W-1:0]  temp_width,
  input  logic [NSRC-1:0]   pend_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              run_q,
  output logic [WID_W-1:0]  width_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              sw_width_wr,
  output logic [NSRC-1:0]   pend_clr
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:WID_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      width_q <= '0;
      mask_q  <= '1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          OFF_RUN:   run_q   <= wr_data[0];
          OFF_WIDTH: width_q <= wr_data[WID_W-1:0];
          OFF_MASK:  mask_q  <= wr_data[NSRC-1:0];
          default: ;
        endcase
      end
      if (temp_load) width_q <= temp_width;
    end
  end

  assign sw_width_wr = wr_en && (wr_addr == OFF_WIDTH);
  assign pend_clr    = (wr_en && (wr_addr == OFF_PEND)) ? wr_data[NSRC-1:0] : '0;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_MASK:   rd_data[NSRC-1:0]  = mask_q;
      OFF_PEND:   rd_data[NSRC-1:0]  = pend_q;
      OFF_SRC:    rd_data[NSRC-1:0]  = pend_q & ~mask_q;
      OFF_RUN:    rd_data[0]         = run_q;
      OFF_WIDTH:  rd_data[WID_W-1:0] = width_q;
      OFF_PERIOD: rd_data            = DATA_W'(PERIOD);
      default:    rd_data            = '0;
    endcase
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int WID_W  = 16,
  parameter int PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WID_W-1:0] width,
  output logic             pwm_out,
  output logic [WID_W-1:0] cnt_q,
  output logic [WID_W-1:0] act_q
);
  localparam logic [WID_W-1:0] LAST = WID_W'(PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      act_q <= width;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      act_q <= width;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_out = run && (cnt_q < act_q);
endmodule

// File: rtl/fan_settle_seq.sv
module fan_settle_seq #(
  parameter int SETTLE_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start,
  output logic done
);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SET_W-1:0] LOAD = SET_W'(SETTLE_CYCLES);

  logic             busy_q;
  logic [SET_W-1:0] left_q;

  assign done = run && busy_q && (left_q == SET_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      left_q <= LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (busy_q) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/fan_irq_ctrl.sv
module fan_irq_ctrl #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] pend_q,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (evt[i]) pend_q[i] <= 1'b1;
      else if (clr[i]) pend_q[i] <= 1'b0;
    end
  end

  assign irq = |(pend_q & ~mask);
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int WID_W         = 16,
  parameter int PERIOD        = 1000,
  parameter int SETTLE_CYCLES = 250_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tach_err,
  input  logic              tach_meas,
  input  logic              temp_req,
  input  logic [WID_W-1:0]  temp_duty,
  output logic              pwm_out,
  output logic              irq
);
  logic             run_q;
  logic [WID_W-1:0] width_q;
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  pend_clr;
  logic [NSRC-1:0]  evt;
  logic             sw_width_wr;
  logic             temp_go;
  logic             settle_done;
  logic [WID_W-1:0] pwm_cnt;
  logic [WID_W-1:0] pwm_act;

  assign temp_go = run_q && temp_req;

  always_comb begin
    evt              = '0;
    evt[EV_PWM_CHG]  = run_q && (sw_width_wr || settle_done);
    evt[EV_TACH_ERR] = run_q && tach_err;
    evt[EV_TEMP_REQ] = temp_go;
    evt[EV_NEW_MEAS] = run_q && tach_meas;
  end

  fan_regs #(.DATA_W(DATA_W), .WID_W(WID_W), .PERIOD(PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .temp_load(temp_go), .temp_width(temp_duty), .pend_q(pend_q),
    .rd_data(rd_data), .run_q(run_q), .width_q(width_q), .mask_q(mask_q),
    .sw_width_wr(sw_width_wr), .pend_clr(pend_clr)
  );

  fan_pwm_gen #(.WID_W(WID_W), .PERIOD(PERIOD)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run(run_q), .width(width_q),
    .pwm_out(pwm_out), .cnt_q(pwm_cnt), .act_q(pwm_act)
  );

  fan_settle_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(run_q), .start(temp_go), .done(settle_done)
  );

  fan_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(pend_clr), .mask(mask_q),
    .pend_q(pend_q), .irq(irq)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int WID_W  = 16,
  parameter int PERIOD = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic              pwm_out,
  input logic              irq,
  input logic [WID_W-1:0]  cnt,
  input logic [WID_W-1:0]  act,
  input logic [3:0]        pend,
  input logic [3:0]        mask,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic              tach_err,
  input logic              temp_req,
  input logic [7:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_period_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'hC0) |-> (rd_data == DATA_W'(PERIOD)));
  assert_pwm_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pwm_out);
  assert_no_latch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !pend[1]) |=> !pend[1]);
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < WID_W'(PERIOD));
  assert_width_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt != WID_W'(PERIOD - 1)) |=> $stable(act));
  assert_sw_width_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && wr_addr == 8'h84) |=> pend[0]);
  assert_temp_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && temp_req) |=> pend[2]);
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tach_err) |=> pend[1]);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.DATA_W(DATA_W), .WID_W(WID_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .pwm_out(pwm_out), .irq(irq),
  .cnt(pwm_cnt), .act(pwm_act), .pend(pend_q), .mask(mask_q),
  .wr_en(wr_en), .wr_addr(wr_addr), .tach_err(tach_err), .temp_req(temp_req),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/fan_pwm_ctrl_bench.sv
module fan_pwm_ctrl_bench;
  localparam int P = 8;
  localparam int S = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tach_err = 1'b0, tach_meas = 1'b0, temp_req = 1'b0;
  logic [15:0] temp_duty = '0;
  logic        pwm_out, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.PERIOD(P), .SETTLE_CYCLES(S)) u_fan_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tach_err(tach_err), .tach_meas(tach_meas),
    .temp_req(temp_req), .temp_duty(temp_duty), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm", {31'd0, pwm_out}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(8'h40, v); check("R1 mask", v, 32'hF);
    rd(8'h44, v); check("R1 pend", v, 0);
    rd(8'h80, v); check("R1 run", v, 0);

    // R2 period read-only
    rd(8'hC0, v); check("R2 period", v, P);
    wr(8'hC0, 32'd5);
    rd(8'hC0, v); check("R2 period after write", v, P);

    // R3 idle core latches nothing and drives no pulse
    wr(8'h84, 32'd4);
    tach_err = 1'b1; tach_meas = 1'b1; @(negedge clk); tach_err = 1'b0; tach_meas = 1'b0;
    rd(8'h44, v); check("R3 pend idle", v, 0);
    count_high(2 * P, hi); check("R3 pwm idle", hi, 0);

    // R4 width sweep
    wr(8'h80, 32'd1);
    for (int w = 0; w <= P + 1; w++) begin
      wr(8'h84, w);
      repeat (2 * P) @(negedge clk);
      count_high(P, hi);
      check("R4 high count", hi, (w < P) ? w : P);
    end

    // R6 software write flags PWM changed
    wr(8'h44, 32'hF);
    rd(8'h44, v); check("R9 clear all", v, 0);
    wr(8'h84, 32'd3);
    rd(8'h44, v); check("R6 pend bit0", v, 32'h1);

    // R10 mask behaviour
    check("R10 irq masked", {31'd0, irq}, 0);
    rd(8'h48, v); check("R10 src masked", v, 0);
    wr(8'h40, 32'hE);
    check("R10 irq unmasked", {31'd0, irq}, 1);
    rd(8'h48, v); check("R10 src unmasked", v, 32'h1);
    wr(8'h40, 32'hF);
    check("R10 irq remasked", {31'd0, irq}, 0);

    // R9 write-0 keeps, write-1 clears, event beats clear
    wr(8'h44, 32'h0);
    rd(8'h44, v); check("R9 write zero", v, 32'h1);
    wr(8'h44, 32'h1);
    rd(8'h44, v); check("R9 write one", v, 0);
    tach_err = 1'b1;
    wr(8'h44, 32'h2);
    tach_err = 1'b0;
    rd(8'h44, v); check("R9 event wins", v, 32'h2);

    // R7 tach strobes
    wr(8'h44, 32'hF);
    tach_meas = 1'b1; @(negedge clk); tach_meas = 1'b0;
    rd(8'h44, v); check("R7 new measurement", v, 32'h8);
    tach_err = 1'b1; @(negedge clk); tach_err = 1'b0;
    rd(8'h44, v); check("R7 tach error", v, 32'hA);

    // R5 boundary: width 3 steady, write 6 during a period
    repeat (2 * P) @(negedge clk);
    prev = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    hi = 1;
    wr_en = 1'b1; wr_addr = 8'h84; wr_data = 32'd6;
    for (int i = 1; i < P; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_out) hi++;
    end
    check("R5 current period keeps old width", hi, 3);
    count_high(P, hi); check("R5 next period new width", hi, 6);

    // R8 temperature request and settle
    wr(8'h44, 32'hF);
    temp_req = 1'b1; temp_duty = 16'd5;
    @(negedge clk);
    temp_req = 1'b0;
    rd(8'h44, v); check("R8 temp flag", v, 32'h4);
    rd(8'h84, v); check("R8 width loaded", v, 5);
    repeat (S - 1) @(negedge clk);
    rd(8'h44, v); check("R8 before settle", v, 32'h4);
    @(negedge clk);
    rd(8'h44, v); check("R8 after settle", v, 32'h5);
    repeat (2 * P) @(negedge clk);
    count_high(P, hi); check("R8 duty applied", hi, 5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule